// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

This block watches the command pins of an SDRAM interface and reports sequences that break the bank-state rules. It never drives the bus. On every rising clock it decodes the chip select and the three command strobes into a command. It tracks whether each of four banks is idle or holds an open row, and it flags a command that the current bank state forbids. Banks close through an explicit precharge, either to one bank or to all of them. A bank also closes by itself after a read or write burst that requested auto-precharge.

A mode register load is accepted only while every bank is idle. It opens a short lockout window, and any executable command inside that window is a violation. For each violation the monitor emits a one-cycle pulse. It also holds the code and bank of the first violation in sticky form until software or a parent block pulses the clear input. A per-bank open vector shows the tracked state at all times, so the monitor can drive a waveform marker or feed a larger scoreboard.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After synchronous reset, `bank_open` is 0000, `err_pulse` is 0, `err_sticky` is 0 and `err_code` is 0.
- R2: With `cs_n` high, the sampled command has no effect: no bank changes state and no violation is raised, even inside a mode-load lockout. With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 000 MODE LOAD, 001 REFRESH and 110 BURST STOP. A NOP changes nothing.
- R3: An ACTIVE to an idle bank sets `bank_open[ba]` after that edge. An ACTIVE to a bank that is already open raises code 1.
- R4: A READ or WRITE to a bank whose `bank_open` bit is 0 raises code 2. A READ or WRITE to an open bank raises nothing.
- R5: A PRECHARGE with `ap_all` low clears only `bank_open[ba]`. With `ap_all` high it clears every bank.
- R6: A READ or WRITE to an open bank with `ap_all` high clears that bank's bit exactly BURST_LEN+T_RP edges after the command edge, and the bit stays set before then. With `ap_all` low the bank stays open.
- R7: A MODE LOAD while any bank is open raises code 3.
- R8: An executable command (neither inhibit nor NOP) sampled within T_MRD-1 edges after a MODE LOAD raises code 4, which takes priority over any other code. NOP and inhibit inside the window raise nothing.
- R9: `err_pulse` is high for the one cycle after each violating edge. `err_sticky`, `err_code` and `err_bank` (the `ba` of the offending command) capture the first violation and hold it while later violations still pulse.
- R10: `err_clr` clears `err_sticky` and sets `err_code` and `err_bank` to 0 after the edge. A violation on the same edge is captured instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| ap_all | input | 1 | Address bit 10: auto-precharge on access, all banks on precharge |
| err_clr | input | 1 | Clears the sticky error record |
| err_pulse | output | 1 | One-cycle violation strobe |
| err_sticky | output | 1 | A violation has been recorded |
| err_code | output | 3 | Code of the first recorded violation |
| err_bank | output | 2 | Bank of the first recorded violation |
| bank_open | output | 4 | Per-bank open-row status |

## Verification
The assertions assume that every input carries a known level at each rising edge. They also assume that reset is held through at least one edge before traffic starts, and that `err_clr` is a synchronous level sampled like the command pins. The stimulus changes pins only on the falling edge and drives one complete command per cycle, with NOP as the default between commands. It never drives the bus during reset. Lockout and auto-precharge windows are timed by counting whole cycles from the command edge.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_ACT,
        CMD_READ,
        CMD_WRITE,
        CMD_PRE,
        CMD_MODE,
        CMD_REFRESH,
        CMD_BSTOP
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_ACT_OPEN    = 3'd1,
        ERR_ACCESS_IDLE = 3'd2,
        ERR_MODE_BUSY   = 3'd3,
        ERR_MRD_LOCK    = 3'd4
    } err_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic cmd_e decode_cmd(pins_t p);
        cmd_e c;
        if (p.cs_n) begin
            c = CMD_INHIBIT;
        end else begin
            case ({p.ras_n, p.cas_n, p.we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b010:  c = CMD_PRE;
                3'b000:  c = CMD_MODE;
                3'b001:  c = CMD_REFRESH;
                default: c = CMD_BSTOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_exec(cmd_e c);
        return !(c == CMD_INHIBIT || c == CMD_NOP);
    endfunction

    function automatic logic is_access(cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/sdcm_bank.sv
module sdcm_bank #(
    parameter int CLOSE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic act_hit,
    input  logic ap_hit,
    input  logic pre_hit,
    output logic open_q
);
    localparam int CW = $clog2(CLOSE_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pre_hit) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (act_hit) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
        end else if (ap_hit) begin
            cnt_q  <= CW'(CLOSE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) open_q <= 1'b0;
        end
    end

    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        act_hit && !pre_hit |=> open_q);

    p_pre_closes_r5: assert property (@(posedge clk) disable iff (rst)
        pre_hit |=> !open_q);

    p_ap_holds_r6: assert property (@(posedge clk) disable iff (rst)
        ap_hit && !pre_hit && !act_hit |=> open_q);

    p_ap_expires_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(1)) && !act_hit && !ap_hit && !pre_hit |=> !open_q);

endmodule

// File: rtl/sdcm_mrd_timer.sv
module sdcm_mrd_timer #(
    parameter int T_MRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_hit,
    output logic locked
);
    localparam int CW   = $clog2(T_MRD + 1);
    localparam int LOAD = T_MRD - 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (mode_hit)      cnt_q <= CW'(LOAD);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign locked = (cnt_q != '0);

    p_lock_after_mode_r8: assert property (@(posedge clk) disable iff (rst)
        mode_hit && (T_MRD > 1) |=> locked);

endmodule

// File: rtl/sdcm_err_latch.sv
module sdcm_err_latch
    import sdcm_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  err_e            viol_code,
    input  logic [BA_W-1:0] viol_bank,
    output logic            pulse,
    output logic            sticky,
    output err_e            code,
    output logic [BA_W-1:0] bank
);
    logic viol;
    assign viol = (viol_code != ERR_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse  <= 1'b0;
            sticky <= 1'b0;
            code   <= ERR_NONE;
            bank   <= '0;
        end else begin
            pulse <= viol;
            if (viol && (!sticky || clr)) begin
                sticky <= 1'b1;
                code   <= viol_code;
                bank   <= viol_bank;
            end else if (clr) begin
                sticky <= 1'b0;
                code   <= ERR_NONE;
                bank   <= '0;
            end
        end
    end

    p_hold_first_r9: assert property (@(posedge clk) disable iff (rst)
        sticky && !clr |=> sticky && $stable(code) && $stable(bank));

    p_code_valid_r9: assert property (@(posedge clk) disable iff (rst)
        sticky |-> code != ERR_NONE);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr && !viol |=> !sticky && code == ERR_NONE);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 1,
    parameter int T_RP      = 2,
    parameter int T_MRD     = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                         ap_all,
    input  logic                         err_clr,
    output logic                         err_pulse,
    output logic                         err_sticky,
    output logic [2:0]                   err_code,
    output logic [$clog2(NUM_BANKS)-1:0] err_bank,
    output logic [NUM_BANKS-1:0]         bank_open
);
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int CLOSE_CYC = BURST_LEN + T_RP;

    cmd_e  cmd;
    pins_t pins;
    logic  locked;
    logic  sel_open;
    err_e  viol_code;
    err_e  code_q;

    assign pins     = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
    assign cmd      = decode_cmd(pins);
    assign sel_open = bank_open[ba];

    always_comb begin
        viol_code = ERR_NONE;
        if (locked && is_exec(cmd)) begin
            viol_code = ERR_MRD_LOCK;
        end else begin
            case (cmd)
                CMD_ACT:   if (sel_open)    viol_code = ERR_ACT_OPEN;
                CMD_READ,
                CMD_WRITE: if (!sel_open)   viol_code = ERR_ACCESS_IDLE;
                CMD_MODE:  if (|bank_open)  viol_code = ERR_MODE_BUSY;
                default:   viol_code = ERR_NONE;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(i));
        sdcm_bank #(.CLOSE_CYC(CLOSE_CYC)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .act_hit (cmd == CMD_ACT && hit),
            .ap_hit  (is_access(cmd) && hit && ap_all && bank_open[i]),
            .pre_hit (cmd == CMD_PRE && (hit || ap_all)),
            .open_q  (bank_open[i])
        );
    end

    sdcm_mrd_timer #(.T_MRD(T_MRD)) u_mrd (
        .clk      (clk),
        .rst      (rst),
        .mode_hit (cmd == CMD_MODE),
        .locked   (locked)
    );

    sdcm_err_latch #(.BA_W(BA_W)) u_err (
        .clk       (clk),
        .rst       (rst),
        .clr       (err_clr),
        .viol_code (viol_code),
        .viol_bank (ba),
        .pulse     (err_pulse),
        .sticky    (err_sticky),
        .code      (code_q),
        .bank      (err_bank)
    );

    assign err_code = code_q;

    p_inhibit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !err_pulse);

    p_act_twice_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_n && {ras_n, cas_n, we_n} == 3'b011 && bank_open[ba] |=> err_pulse);

    p_access_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !cs_n && ras_n && !cas_n && !bank_open[ba] |=> err_pulse);

    p_mode_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_n && {ras_n, cas_n, we_n} == 3'b000 && (|bank_open) |=> err_pulse);

    p_lock_flag_r8: assert property (@(posedge clk) disable iff (rst)
        locked && !cs_n && !(ras_n && cas_n && we_n) |=> err_pulse);

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

    localparam int CLOSE = 1 + 2;
    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                           C_WR = 3'b100, C_PRE = 3'b010, C_MODE = 3'b000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic ap_all = 1'b0, err_clr = 1'b0;
    logic err_pulse, err_sticky;
    logic [2:0] err_code;
    logic [1:0] err_bank;
    logic [3:0] bank_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_cmd_monitor dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .ap_all(ap_all), .err_clr(err_clr),
        .err_pulse(err_pulse), .err_sticky(err_sticky), .err_code(err_code),
        .err_bank(err_bank), .bank_open(bank_open)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] rcw, input logic [1:0] b, input logic a10,
                         input logic cs = 1'b0, input logic clr = 1'b0);
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; ap_all = a10; err_clr = clr;
        @(posedge clk);
        #1;
        cs_n = 1'b0; {ras_n, cas_n, we_n} = C_NOP; ba = 2'd0; ap_all = 1'b0; err_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 2'd0, 1'b0);
    endtask

    task automatic clear_err();
        issue(C_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 bank_open", 32'(bank_open), 0);
        check("R1 err_pulse", 32'(err_pulse), 0);
        check("R1 err_sticky", 32'(err_sticky), 0);
        check("R1 err_code", 32'(err_code), 0);
    endtask

    task automatic t_inhibit();
        issue(C_ACT, 2'd0, 1'b0, 1'b1);
        check("R2 inhibited ACT leaves bank idle", 32'(bank_open), 0);
        check("R2 inhibited ACT no pulse", 32'(err_pulse), 0);
        issue(C_NOP, 2'd0, 1'b0);
        check("R2 NOP no change", 32'(bank_open), 0);
    endtask

    task automatic t_act();
        issue(C_ACT, 2'd1, 1'b0);
        check("R3 ACT opens bank 1", 32'(bank_open), 32'h2);
        check("R3 legal ACT no pulse", 32'(err_pulse), 0);
        issue(C_ACT, 2'd1, 1'b0);
        check("R3 ACT to open bank pulses", 32'(err_pulse), 1);
        check("R3 code", 32'(err_code), 1);
        check("R9 bank", 32'(err_bank), 1);
        check("R9 sticky", 32'(err_sticky), 1);
        idle(1);
        check("R9 pulse lasts one cycle", 32'(err_pulse), 0);
        check("R9 sticky holds", 32'(err_sticky), 1);
        clear_err();
        check("R10 clear sticky", 32'(err_sticky), 0);
        check("R10 clear code", 32'(err_code), 0);
        check("R10 clear bank", 32'(err_bank), 0);
    endtask

    task automatic t_access();
        issue(C_RD, 2'd2, 1'b0);
        check("R4 READ idle bank pulses", 32'(err_pulse), 1);
        check("R4 READ idle code", 32'(err_code), 2);
        check("R4 READ idle bank", 32'(err_bank), 2);
        clear_err();
        issue(C_WR, 2'd1, 1'b0);
        check("R4 WRITE open bank no pulse", 32'(err_pulse), 0);
        check("R4 WRITE open bank keeps state", 32'(bank_open), 32'h2);
    endtask

    task automatic t_pre();
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_ACT, 2'd2, 1'b0);
        check("R3 three banks open", 32'(bank_open), 32'h7);
        issue(C_PRE, 2'd2, 1'b0);
        check("R5 single-bank precharge", 32'(bank_open), 32'h3);
        issue(C_PRE, 2'd3, 1'b1);
        check("R5 precharge all", 32'(bank_open), 0);
        check("R5 no pulse", 32'(err_sticky), 0);
    endtask

    task automatic t_autopre();
        issue(C_ACT, 2'd3, 1'b0);
        issue(C_WR, 2'd3, 1'b1);
        check("R6 open at command edge", 32'(bank_open), 32'h8);
        for (int i = 1; i < CLOSE; i++) begin
            idle(1);
            check("R6 still open inside window", 32'(bank_open), 32'h8);
        end
        idle(1);
        check("R6 closed after window", 32'(bank_open), 0);
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_RD, 2'd0, 1'b0);
        idle(CLOSE + 2);
        check("R6 no auto-precharge keeps open", 32'(bank_open), 32'h1);
        check("R6 no errors", 32'(err_sticky), 0);
    endtask

    task automatic t_mode();
        issue(C_MODE, 2'd0, 1'b0);
        check("R7 mode load with open bank", 32'(err_code), 3);
        check("R7 pulse", 32'(err_pulse), 1);
        clear_err();
        issue(C_PRE, 2'd0, 1'b1);
        idle(2);
        issue(C_MODE, 2'd0, 1'b0);
        check("R7 mode load all idle legal", 32'(err_pulse), 0);
        issue(C_ACT, 2'd1, 1'b0);
        check("R8 ACT in lockout pulses", 32'(err_pulse), 1);
        check("R8 lockout code has priority", 32'(err_code), 4);
        check("R8 lockout bank", 32'(err_bank), 1);
        clear_err();
        issue(C_PRE, 2'd0, 1'b1);
        idle(2);
        issue(C_MODE, 2'd0, 1'b0);
        issue(C_NOP, 2'd0, 1'b0);
        check("R8 NOP in lockout quiet", 32'(err_pulse), 0);
        issue(C_ACT, 2'd2, 1'b0);
        check("R8 ACT after lockout legal", 32'(err_pulse), 0);
        issue(C_PRE, 2'd0, 1'b1);
        issue(C_MODE, 2'd0, 1'b0);
        issue(C_ACT, 2'd1, 1'b0, 1'b1);
        check("R2 inhibit in lockout quiet", 32'(err_pulse), 0);
        check("R2 inhibit in lockout no state", 32'(bank_open), 0);
    endtask

    task automatic t_first_hold();
        idle(2);
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_RD, 2'd2, 1'b0);
        check("R9 later violation pulses", 32'(err_pulse), 1);
        check("R9 first code held", 32'(err_code), 1);
        check("R9 first bank held", 32'(err_bank), 0);
        issue(C_WR, 2'd3, 1'b0, 1'b0, 1'b1);
        check("R10 clear with violation captures", 32'(err_code), 2);
        check("R10 captured bank", 32'(err_bank), 3);
        check("R10 still sticky", 32'(err_sticky), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_inhibit();
        t_act();
        t_access();
        t_pre();
        t_autopre();
        t_mode();
        t_first_hold();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule